// File: doc/BRIEF.md
# Sample Clock and Channel Scanner

This block sets the pace and the channel order of a multi-channel acquisition. It takes up to four master timebases, each arriving as a one-cycle enable pulse on the system clock. It picks one of them and divides its pulse rate by 1, 2, 4 or 8. On every divided tick it issues a one-cycle sample strobe together with the channel number that the converter should sample. It then steps a channel pointer through a fixed scan pattern.

Software programs the block through one 16-bit configuration word. A write loads the scan code, the timebase select and the divisor exponent. The same write restarts both the divider and the scan at the first channel of the new pattern. A scan-end flag rides with the strobe of the last channel in each pass, so that complete scans can be counted downstream. A build parameter states how many timebases exist on a given variant. A select value that names a missing timebase yields no strobes.

Top module: `scan_pacer`

## Requirements
- R1: While reset is asserted and after its release, `sampleStrobe` and `scanLast` are 0, `sampleChan` is 0, and the block is idle (scan code 000) until the first configuration write.
- R2: Configuration word fields: bits [2:0] scan code, bits [4:3] timebase select, bits [6:5] divisor exponent; bits [15:7] are ignored. A write clears the divider count and sets the channel pointer to the first channel of the new pattern. A timebase pulse in the cycle of a write is not counted, and no strobe appears in the cycle after a write.
- R3: Only pulses on the selected `mclkTick` line are counted. The strobe is asserted in the cycle after the 2^exponent-th counted pulse since the last strobe or write. Pulses on other lines have no effect.
- R4: Scan code 1xx samples only the channel given by code bits [1:0], and `scanLast` accompanies every strobe.
- R5: Scan code 010 alternates channels 0,1 and code 011 alternates channels 2,3, each starting with the lower channel. `scanLast` accompanies the higher channel.
- R6: Scan code 001 steps through channels 0,1,2,3 and then wraps to 0. `scanLast` accompanies channel 3.
- R7: Scan code 000 is idle: no strobe is produced whatever the pulses.
- R8: A select value at or above the `NUM_CLOCKS` parameter produces no strobes.
- R9: `sampleChan` changes only together with a strobe and holds its value between strobes. `scanLast` is never high without `sampleStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | One-cycle configuration write enable |
| cfgWord | input | 16 | Configuration word (fields per R2) |
| mclkTick | input | 4 | One-cycle enable pulses of the master timebases |
| sampleStrobe | output | 1 | One-cycle conversion strobe |
| sampleChan | output | 2 | Channel for the current strobe, held between strobes |
| scanLast | output | 1 | High with the strobe of the last channel of a scan |

## Verification
The bench rewrites the configuration in the middle of a scan, with a pulse present in the write cycle. A design that kept its pointer or divider count would continue the old sequence, and one that counted that pulse would strobe a period early. It drives the largest exponent together with pulses on unselected lines. A divider that compared against the wrong limit, or that listened to every line, would strobe too often. A second instance built with three timebases runs on select 3 and must stay silent; a decoder without the existence guard would follow line 3. Random writes and pulse patterns then check the wrap of each pattern and the placement of the scan-end flag on the correct channel.

// File: rtl/scan_pacer_pkg.sv
package scan_pacer_pkg;
  localparam int CFG_W    = 16;
  localparam int SCAN_W   = 3;
  localparam int SEL_W    = 2;
  localparam int DIV_W    = 2;
  localparam int CHAN_W   = 2;
  localparam int SCAN_LSB = 0;
  localparam int SEL_LSB  = SCAN_LSB + SCAN_W;
  localparam int DIV_LSB  = SEL_LSB + SEL_W;
  localparam int MAX_CLOCKS = 1 << SEL_W;
  localparam int CNT_W    = (1 << DIV_W) - 1;

  localparam logic [SCAN_W-1:0] SCAN_IDLE    = 3'b000;
  localparam logic [SCAN_W-1:0] SCAN_ALL     = 3'b001;
  localparam logic [SCAN_W-1:0] SCAN_PAIR_LO = 3'b010;
  localparam logic [SCAN_W-1:0] SCAN_PAIR_HI = 3'b011;

  typedef logic [SCAN_W-1:0] scan_code_t;

  typedef struct packed {
    logic       load;
    logic       fire;
    scan_code_t loadCode;
  } pacer_strobe_t;
endpackage

// File: rtl/scan_pacer_ctrl.sv
module scan_pacer_ctrl
  import scan_pacer_pkg::*;
#(
  parameter int NUM_CLOCKS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrite,
  input  logic [CFG_W-1:0]      cfgWord,
  input  logic [MAX_CLOCKS-1:0] mclkTick,
  output scan_code_t            scanCode,
  output pacer_strobe_t         strobes
);
  logic [SEL_W-1:0]      selReg;
  logic [DIV_W-1:0]      divReg;
  logic [CNT_W-1:0]      divCnt;
  logic [CNT_W-1:0]      cntLimit;
  logic [MAX_CLOCKS-1:0] lineLive;
  logic                  countTick;

  for (genvar i = 0; i < MAX_CLOCKS; i++) begin : g_line
    if (i < NUM_CLOCKS) begin : g_present
      assign lineLive[i] = mclkTick[i];
    end else begin : g_absent
      assign lineLive[i] = 1'b0;
    end
  end

  assign cntLimit  = (CNT_W'(1) << divReg) - CNT_W'(1);
  assign countTick = lineLive[selReg] && (scanCode != SCAN_IDLE) && !cfgWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanCode <= SCAN_IDLE;
      selReg   <= '0;
      divReg   <= '0;
      divCnt   <= '0;
    end else if (cfgWrite) begin
      scanCode <= cfgWord[SCAN_LSB +: SCAN_W];
      selReg   <= cfgWord[SEL_LSB +: SEL_W];
      divReg   <= cfgWord[DIV_LSB +: DIV_W];
      divCnt   <= '0;
    end else if (countTick) begin
      divCnt <= (divCnt == cntLimit) ? '0 : divCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.load     = cfgWrite;
    strobes.loadCode = cfgWord[SCAN_LSB +: SCAN_W];
    strobes.fire     = countTick && (divCnt == cntLimit);
  end

  // R3: the divider count never passes the limit set by the exponent
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= cntLimit);
  // R2: a write leaves the divider at zero
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> divCnt == '0);
endmodule

// File: rtl/scan_pacer_datapath.sv
module scan_pacer_datapath
  import scan_pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pacer_strobe_t     strobes,
  input  scan_code_t        scanCode,
  output logic              sampleStrobe,
  output logic [CHAN_W-1:0] sampleChan,
  output logic              scanLast
);
  logic [CHAN_W-1:0] chanPtr;
  logic [CHAN_W-1:0] firstChan;
  logic [CHAN_W-1:0] nextChan;
  logic              ptrIsLast;

  function automatic logic [CHAN_W-1:0] patternStart(input scan_code_t code);
    if (code[SCAN_W-1])          return code[CHAN_W-1:0];
    else if (code == SCAN_PAIR_HI) return CHAN_W'(2);
    else                          return '0;
  endfunction

  always_comb begin
    firstChan = patternStart(strobes.loadCode);
    if (scanCode[SCAN_W-1])           ptrIsLast = 1'b1;
    else if (scanCode == SCAN_PAIR_LO) ptrIsLast = (chanPtr == CHAN_W'(1));
    else                               ptrIsLast = (chanPtr == CHAN_W'(3));
    nextChan = ptrIsLast ? patternStart(scanCode) : chanPtr + CHAN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanPtr      <= '0;
      sampleChan   <= '0;
      sampleStrobe <= 1'b0;
      scanLast     <= 1'b0;
    end else begin
      sampleStrobe <= strobes.fire;
      scanLast     <= strobes.fire && ptrIsLast;
      if (strobes.fire) sampleChan <= chanPtr;
      if (strobes.load)      chanPtr <= firstChan;
      else if (strobes.fire) chanPtr <= nextChan;
    end
  end

  // R9: scan-end flag only with a strobe
  a_r9_last_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    scanLast |-> sampleStrobe);
  // R9: channel output holds when no strobe is issued
  a_r9_chan_holds: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |-> $stable(sampleChan));
  // R4: single-channel scan stays on the coded channel
  a_r4_single: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && scanCode[SCAN_W-1]) |-> (sampleChan == scanCode[CHAN_W-1:0] && scanLast));
  // R5: pair scans stay within their pair
  a_r5_pair_lo: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && scanCode == SCAN_PAIR_LO) |-> sampleChan <= CHAN_W'(1));
  a_r5_pair_hi: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && scanCode == SCAN_PAIR_HI) |-> sampleChan >= CHAN_W'(2));
  // R6: in the four-channel scan only channel 3 closes a scan
  a_r6_all_last: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && scanCode == SCAN_ALL) |-> (scanLast == (sampleChan == CHAN_W'(3))));
  // R7: idle code yields no strobe
  a_r7_idle: assert property (@(posedge clk) disable iff (!rstN)
    (scanCode == SCAN_IDLE) |=> !sampleStrobe);
  // R2: no strobe right after a write
  a_r2_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !sampleStrobe);
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
  import scan_pacer_pkg::*;
#(
  parameter int NUM_CLOCKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic [15:0] cfgWord,
  input  logic [3:0]  mclkTick,
  output logic        sampleStrobe,
  output logic [1:0]  sampleChan,
  output logic        scanLast
);
  scan_code_t    scanCode;
  pacer_strobe_t strobes;

  scan_pacer_ctrl #(.NUM_CLOCKS(NUM_CLOCKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrite (cfgWrite),
    .cfgWord  (cfgWord),
    .mclkTick (mclkTick),
    .scanCode (scanCode),
    .strobes  (strobes)
  );

  scan_pacer_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .scanCode     (scanCode),
    .sampleStrobe (sampleStrobe),
    .sampleChan   (sampleChan),
    .scanLast     (scanLast)
  );
endmodule

// File: tb/scan_pacer_test.sv
`timescale 1ns/1ps
module scan_pacer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [15:0] cfgWord = '0;
  logic [3:0]  mclkTick = '0;
  logic        sampleStrobe, scanLast, strobe3, last3;
  logic [1:0]  sampleChan, chan3;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  int refCode = 0, refSel = 0, refDiv = 0, refCnt = 0, refIdx = 0;
  int pat[$];
  bit expStrobe = 0, expLast = 0;
  int expChan = 0;

  always #5 clk = ~clk;

  scan_pacer uut (.clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .mclkTick(mclkTick), .sampleStrobe(sampleStrobe), .sampleChan(sampleChan), .scanLast(scanLast));

  scan_pacer #(.NUM_CLOCKS(3)) uut3 (.clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .mclkTick(mclkTick), .sampleStrobe(strobe3), .sampleChan(chan3), .scanLast(last3));

  function automatic logic [15:0] mkWord(input int code, input int sel, input int dv, input int junk);
    return 16'((junk << 7) | (dv << 5) | (sel << 3) | code);
  endfunction

  task automatic buildPattern(input int code);
    pat.delete();
    if (code >= 4) pat.push_back(code % 4);
    else if (code == 1) begin pat.push_back(0); pat.push_back(1); pat.push_back(2); pat.push_back(3); end
    else if (code == 2) begin pat.push_back(0); pat.push_back(1); end
    else if (code == 3) begin pat.push_back(2); pat.push_back(3); end
  endtask

  task automatic compare();
    checks++;
    if (sampleStrobe !== expStrobe || sampleChan !== 2'(expChan) || scanLast !== expLast) begin
      fails++;
      $display("FAIL %s: strobe/chan/last got %b/%0d/%b expected %b/%0d/%b at %0t",
               curReq, sampleStrobe, sampleChan, scanLast, expStrobe, expChan, expLast, $time);
    end
    // R8: three-timebase build must be silent on select 3
    checks++;
    if (strobe3 !== (expStrobe && refSel != 3)) begin
      fails++;
      $display("FAIL R8: three-clock strobe got %b expected %b at %0t",
               strobe3, expStrobe && refSel != 3, $time);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] word, input logic [3:0] tk);
    cfgWrite = w; cfgWord = word; mclkTick = tk;
    @(posedge clk);
    expStrobe = 0; expLast = 0;
    if (w) begin
      refCode = word[2:0]; refSel = word[4:3]; refDiv = word[6:5];
      refCnt = 0; refIdx = 0; buildPattern(refCode);
    end else if (refCode != 0 && tk[refSel]) begin
      refCnt++;
      if (refCnt == (1 << refDiv)) begin
        refCnt = 0;
        expStrobe = 1;
        expChan = pat[refIdx];
        expLast = (refIdx == pat.size() - 1);
        refIdx = (refIdx + 1) % pat.size();
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic runTicks(input int n, input logic [3:0] tk);
    for (int i = 0; i < n; i++) step(1'b0, cfgWord, tk);
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    compare();
    rstN = 1'b1;
    @(negedge clk);
    compare();
    runTicks(4, 4'hF);

    // R2 R4: single channel 2, junk in upper bits, every pulse strobes
    curReq = "R4";
    step(1'b1, mkWord(6, 0, 0, 9'h1FF), 4'hF);
    runTicks(10, 4'hF);

    // R5 R3: pair 0/1, exponent 1 on line 1, noise on other lines
    curReq = "R5";
    step(1'b1, mkWord(2, 1, 1, 0), 4'h0);
    for (int i = 0; i < 16; i++) step(1'b0, cfgWord, (i % 2 == 0) ? 4'b0010 : 4'b1101);
    // R5: pair 2/3, exponent 2 on line 2
    step(1'b1, mkWord(3, 2, 2, 0), 4'h0);
    runTicks(24, 4'b0100);

    // R6 R8: all four channels, exponent 3 on line 3
    curReq = "R6";
    step(1'b1, mkWord(1, 3, 3, 0), 4'h0);
    runTicks(70, 4'b1000);
    runTicks(20, 4'b0111);

    // R7: idle code with pulses everywhere
    curReq = "R7";
    step(1'b1, mkWord(0, 0, 0, 0), 4'hF);
    runTicks(12, 4'hF);

    // R2: rewrite mid-scan with a pulse in the write cycle
    curReq = "R2";
    step(1'b1, mkWord(1, 0, 0, 0), 4'h0);
    runTicks(2, 4'b0001);
    step(1'b1, mkWord(1, 0, 0, 0), 4'b0001);
    runTicks(6, 4'b0001);
    step(1'b1, mkWord(1, 0, 1, 0), 4'h0);
    runTicks(3, 4'b0001);
    step(1'b1, mkWord(3, 0, 1, 0), 4'b0001);
    runTicks(6, 4'b0001);

    // R3 R9: random configurations and pulses
    curReq = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) step(1'b1, 16'($urandom), 4'($urandom));
      else step(1'b0, cfgWord, 4'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule